// File: doc/BRIEF.md
# Dual-Direction Cross-Clock Mailbox

This block sits beside a bidirectional queue and gives two independent ports, each on its own clock, a side channel for single command words. The A-to-B mailbox takes a word written by port A and holds it for port B to read. The B-to-A mailbox does the same in the other direction. Each mailbox has an active-low full flag, kept in the domain of the port that writes it. The writer sees the flag go LOW on the clock edge that stores its word. While the flag is LOW, further writes from that port are dropped.

When the far port reads the mailbox, it sends a release event back across the clock boundary, and the writer's flag then returns HIGH. A read does not erase the stored word, so it can be read again; only a newly accepted write changes it. Each port's read data bus shows the incoming mailbox when that port's mailbox select is HIGH. When the select is LOW, the bus passes through the queue output word that the port is given.

Top module: `xmb_top`

## Requirements
- R1: After reset, both full flags (`a_tx_full_n`, `b_tx_full_n`) are HIGH.
- R2: A rising clock A edge with `a_sel`=1, `a_wr`=1, `a_en`=1, `a_mb`=1 while `a_tx_full_n` is HIGH stores `a_wdata` in the A-to-B mailbox and drives `a_tx_full_n` LOW after that edge.
- R3: A rising clock B edge with `b_sel`=1, `b_wr`=1, `b_en`=1, `b_mb`=1 while `b_tx_full_n` is HIGH stores `b_wdata` in the B-to-A mailbox and drives `b_tx_full_n` LOW after that edge.
- R4: A mailbox write made while that mailbox's full flag is LOW is ignored: the flag stays LOW and the stored word is unchanged.
- R5: A port transfer with `*_mb`=0, or any cycle with `*_sel`=0 or `*_en`=0, leaves the mailboxes and their full flags unchanged.
- R6: A port B read (`b_sel`=1, `b_wr`=0, `b_en`=1, `b_mb`=1) returns `a_tx_full_n` HIGH on the third or fourth rising clock A edge after the read edge.
- R7: A port A read (`a_sel`=1, `a_wr`=0, `a_en`=1, `a_mb`=1) returns `b_tx_full_n` HIGH on the third or fourth rising clock B edge after the read edge.
- R8: Reading a mailbox does not change its contents, and a second read returns the same word.
- R9: `b_rdata` equals the A-to-B mailbox word when `b_mb`=1 and equals `b_fifo_q` when `b_mb`=0. `a_rdata` equals the B-to-A mailbox word when `a_mb`=1 and equals `a_fifo_q` when `a_mb`=0.
- R10: A queue read (`*_mb`=0) does not return the opposite port's full flag HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released separately in each domain |
| a_sel | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A transfer enable |
| a_mb | input | 1 | Port A mailbox select: 1 mailbox, 0 queue |
| a_wdata | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output word presented to port A |
| a_rdata | output | 36 | Port A read data |
| a_tx_full_n | output | 1 | A-to-B mailbox full flag, active low, clock A domain |
| b_sel | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B transfer enable |
| b_mb | input | 1 | Port B mailbox select: 1 mailbox, 0 queue |
| b_wdata | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output word presented to port B |
| b_rdata | output | 36 | Port B read data |
| b_tx_full_n | output | 1 | B-to-A mailbox full flag, active low, clock B domain |

## Verification
The main function is tried in four ways:
- An accepted write followed by a mailbox read. This shows that the word crosses the boundary and that the release arrives in the expected window of destination edges.
- A second write while the flag is LOW. Reading back the first word afterwards tells a dropped write apart from an overwrite.
- Queue-side transfers and disabled cycles, mixed in on both ports. These show that only a fully qualified mailbox operation moves a flag.
- Repeated reads, and reads with mailbox select LOW. These separate a non-destructive read from a read that clears data, and a mailbox read from a queue read that must not release the writer.

// File: rtl/xmb_pkg.sv
`timescale 1ns/1ps
package xmb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_MB_WR,
    OP_MB_RD,
    OP_Q_XFER
  } op_e;

  function automatic op_e decode_op(input logic sel, input logic wr,
                                    input logic en, input logic mb);
    op_e res;
    if (!(sel && en))  res = OP_IDLE;
    else if (!mb)      res = OP_Q_XFER;
    else if (wr)       res = OP_MB_WR;
    else               res = OP_MB_RD;
    return res;
  endfunction

endpackage

// File: rtl/xmb_rst_sync.sv
`timescale 1ns/1ps
module xmb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/xmb_pulse_xfer.sv
`timescale 1ns/1ps
module xmb_pulse_xfer #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_src_n,
  input  logic pulse_src,
  input  logic clk_dst,
  input  logic rst_dst_n,
  output logic pulse_dst
);
  localparam int unsigned CHAIN = STAGES + 1;

  // source side: one toggle per event
  logic tgl_q;
  logic tgl_d;

  always_comb begin
    tgl_d = tgl_q;
    if (pulse_src) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  // destination side: synchronizer stages plus one history bit
  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], tgl_q};
  end

  always_ff @(posedge clk_dst or negedge rst_dst_n) begin
    if (!rst_dst_n) chain_q <= '0;
    else            chain_q <= chain_d;
  end

  assign pulse_dst = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/xmb_slot.sv
`timescale 1ns/1ps
module xmb_slot #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         release_pulse,
  output logic [W-1:0] data_q,
  output logic         full_n
);
  logic         flag_q;
  logic         flag_d;
  logic         load;
  logic [W-1:0] data_d;

  assign load = wr_req & flag_q;

  // an accepted write wins over a release seen in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (load)               flag_d = 1'b0;
    else if (release_pulse) flag_d = 1'b1;
  end

  always_comb begin
    data_d = data_q;
    if (load) data_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign full_n = flag_q;
endmodule

// File: rtl/xmb_top.sv
`timescale 1ns/1ps
module xmb_top
  import xmb_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic              a_en,
  input  logic              a_mb,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [DATA_W-1:0] a_fifo_q,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_tx_full_n,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic              b_en,
  input  logic              b_mb,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] b_fifo_q,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_tx_full_n
);
  logic rst_a_n;
  logic rst_b_n;
  op_e  a_op;
  op_e  b_op;
  logic a_mb_wr;
  logic a_mb_rd;
  logic b_mb_wr;
  logic b_mb_rd;
  logic ab_release;
  logic ba_release;
  logic [DATA_W-1:0] ab_q;
  logic [DATA_W-1:0] ba_q;

  xmb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
    .clk(clk_a), .arst_n(rst_n), .srst_n(rst_a_n)
  );
  xmb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
    .clk(clk_b), .arst_n(rst_n), .srst_n(rst_b_n)
  );

  always_comb begin
    a_op = decode_op(a_sel, a_wr, a_en, a_mb);
    b_op = decode_op(b_sel, b_wr, b_en, b_mb);
  end

  assign a_mb_wr = (a_op == OP_MB_WR);
  assign a_mb_rd = (a_op == OP_MB_RD);
  assign b_mb_wr = (b_op == OP_MB_WR);
  assign b_mb_rd = (b_op == OP_MB_RD);

  // A-to-B mailbox: stored and flagged in clock A, released by port B
  xmb_slot #(.W(DATA_W)) u_slot_ab (
    .clk(clk_a), .rst_n(rst_a_n), .wr_req(a_mb_wr), .wr_data(a_wdata),
    .release_pulse(ab_release), .data_q(ab_q), .full_n(a_tx_full_n)
  );
  xmb_pulse_xfer #(.STAGES(SYNC_STAGES)) u_rel_ab (
    .clk_src(clk_b), .rst_src_n(rst_b_n), .pulse_src(b_mb_rd),
    .clk_dst(clk_a), .rst_dst_n(rst_a_n), .pulse_dst(ab_release)
  );

  // B-to-A mailbox: stored and flagged in clock B, released by port A
  xmb_slot #(.W(DATA_W)) u_slot_ba (
    .clk(clk_b), .rst_n(rst_b_n), .wr_req(b_mb_wr), .wr_data(b_wdata),
    .release_pulse(ba_release), .data_q(ba_q), .full_n(b_tx_full_n)
  );
  xmb_pulse_xfer #(.STAGES(SYNC_STAGES)) u_rel_ba (
    .clk_src(clk_a), .rst_src_n(rst_a_n), .pulse_src(a_mb_rd),
    .clk_dst(clk_b), .rst_dst_n(rst_b_n), .pulse_dst(ba_release)
  );

  assign a_rdata = a_mb ? ba_q : a_fifo_q;
  assign b_rdata = b_mb ? ab_q : b_fifo_q;
endmodule

// File: rtl/xmb_check.sv
`timescale 1ns/1ps
module xmb_check #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_a_n,
  input logic         rst_b_n,
  input logic         a_mb_wr,
  input logic         b_mb_wr,
  input logic         a_tx_full_n,
  input logic         b_tx_full_n,
  input logic [W-1:0] a_wdata,
  input logic [W-1:0] b_wdata,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q
);
  AST_AB_ACCEPT: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_mb_wr && a_tx_full_n) |=> (!a_tx_full_n && ab_q == $past(a_wdata))); // R2

  AST_BA_ACCEPT: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_mb_wr && b_tx_full_n) |=> (!b_tx_full_n && ba_q == $past(b_wdata))); // R3

  AST_AB_HOLD_WHILE_FULL: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_tx_full_n |=> $stable(ab_q)); // R4

  AST_BA_HOLD_WHILE_FULL: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_tx_full_n |=> $stable(ba_q)); // R4

  AST_AB_FLAG_FALLS_ON_WRITE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_tx_full_n && !a_mb_wr) |=> a_tx_full_n); // R5

  AST_BA_FLAG_FALLS_ON_WRITE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_tx_full_n && !b_mb_wr) |=> b_tx_full_n); // R5

  AST_AB_DATA_ONLY_BY_WRITE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !$stable(ab_q) |-> $past(a_mb_wr)); // R8

  AST_BA_DATA_ONLY_BY_WRITE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !$stable(ba_q) |-> $past(b_mb_wr)); // R8
endmodule

bind xmb_top xmb_check #(.W(DATA_W)) u_xmb_check (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
  .a_mb_wr(a_mb_wr), .b_mb_wr(b_mb_wr),
  .a_tx_full_n(a_tx_full_n), .b_tx_full_n(b_tx_full_n),
  .a_wdata(a_wdata), .b_wdata(b_wdata), .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/test_xmb_top.sv
`timescale 1ns/1ps
module test_xmb_top;
  localparam int W = 36;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n;
  logic a_sel, a_wr, a_en, a_mb;
  logic b_sel, b_wr, b_en, b_mb;
  logic [W-1:0] a_wdata, a_fifo_q, a_rdata;
  logic [W-1:0] b_wdata, b_fifo_q, b_rdata;
  logic a_tx_full_n, b_tx_full_n;

  int n_chk = 0;
  int n_fail = 0;
  int a_cnt = 0;
  int b_cnt = 0;
  bit done = 1'b0;

  always #2 clk_a = ~clk_a;           // 250 MHz
  initial begin
    #1;
    forever #3.5 clk_b = ~clk_b;      // unrelated second clock
  end

  always @(posedge clk_a) a_cnt <= a_cnt + 1;
  always @(posedge clk_b) b_cnt <= b_cnt + 1;

  xmb_top i_xmb_top (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_en(a_en), .a_mb(a_mb),
    .a_wdata(a_wdata), .a_fifo_q(a_fifo_q), .a_rdata(a_rdata),
    .a_tx_full_n(a_tx_full_n),
    .b_sel(b_sel), .b_wr(b_wr), .b_en(b_en), .b_mb(b_mb),
    .b_wdata(b_wdata), .b_fifo_q(b_fifo_q), .b_rdata(b_rdata),
    .b_tx_full_n(b_tx_full_n)
  );

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic sel, input logic wr, input logic en,
                      input logic mb, input logic [W-1:0] d,
                      output logic [W-1:0] rd, output int start);
    @(negedge clk_a);
    a_sel = sel; a_wr = wr; a_en = en; a_mb = mb; a_wdata = d;
    #0.5 rd = a_rdata;
    @(posedge clk_a);
    start = b_cnt;
    @(negedge clk_a);
    a_sel = 0; a_wr = 0; a_en = 0; a_mb = 0;
  endtask

  task automatic b_op(input logic sel, input logic wr, input logic en,
                      input logic mb, input logic [W-1:0] d,
                      output logic [W-1:0] rd, output int start);
    @(negedge clk_b);
    b_sel = sel; b_wr = wr; b_en = en; b_mb = mb; b_wdata = d;
    #0.5 rd = b_rdata;
    @(posedge clk_b);
    start = a_cnt;
    @(negedge clk_b);
    b_sel = 0; b_wr = 0; b_en = 0; b_mb = 0;
  endtask

  task automatic wait_a_free(input int start, output int n);
    while (!a_tx_full_n && (a_cnt - start) < 10) begin
      @(posedge clk_a);
      #1;
    end
    n = a_cnt - start;
  endtask

  task automatic wait_b_free(input int start, output int n);
    while (!b_tx_full_n && (b_cnt - start) < 10) begin
      @(posedge clk_b);
      #1;
    end
    n = b_cnt - start;
  endtask

  task automatic settle();
    repeat (10) @(posedge clk_a);
    repeat (6) @(posedge clk_b);
  endtask

  task automatic t_reset();
    check(a_tx_full_n === 1'b1, "R1 a_tx_full_n after reset", W'(a_tx_full_n), W'(1));
    check(b_tx_full_n === 1'b1, "R1 b_tx_full_n after reset", W'(b_tx_full_n), W'(1));
  endtask

  task automatic t_read_mux();
    logic [W-1:0] rd;
    int s;
    a_fifo_q = 36'h0_AAAA_5555;
    b_fifo_q = 36'h5_1234_ABCD;
    a_op(1, 0, 1, 0, '0, rd, s);
    check(rd === 36'h0_AAAA_5555, "R9 a_rdata from queue when a_mb=0", rd, 36'h0_AAAA_5555);
    b_op(1, 0, 1, 0, '0, rd, s);
    check(rd === 36'h5_1234_ABCD, "R9 b_rdata from queue when b_mb=0", rd, 36'h5_1234_ABCD);
    a_op(1, 0, 1, 1, '0, rd, s);
    check(rd === '0, "R9 a_rdata from empty B-to-A mailbox", rd, '0);
    settle();
  endtask

  task automatic t_ab_pass(input logic [W-1:0] d);
    logic [W-1:0] rd;
    int s, n;
    a_op(1, 1, 1, 1, d, rd, s);
    check(a_tx_full_n === 1'b0, "R2 a_tx_full_n low after write", W'(a_tx_full_n), W'(0));
    b_op(1, 0, 1, 1, '0, rd, s);
    check(rd === d, "R9 b_rdata shows A-to-B mailbox", rd, d);
    wait_a_free(s, n);
    check(n >= 3 && n <= 4, "R6 clock A edges until release", W'(n), W'(3));
    settle();
  endtask

  task automatic t_blocked_write(input logic [W-1:0] d1, input logic [W-1:0] d2);
    logic [W-1:0] rd;
    int s, n;
    a_op(1, 1, 1, 1, d1, rd, s);
    a_op(1, 1, 1, 1, d2, rd, s);
    check(a_tx_full_n === 1'b0, "R4 flag stays low after dropped write", W'(a_tx_full_n), W'(0));
    b_op(1, 0, 1, 1, '0, rd, s);
    check(rd === d1, "R4 first word kept over dropped write", rd, d1);
    wait_a_free(s, n);
    settle();
    b_op(1, 0, 1, 1, '0, rd, s);
    check(rd === d1, "R8 second read returns same word", rd, d1);
    settle();
    check(a_tx_full_n === 1'b1, "R8 flag high after repeated read", W'(a_tx_full_n), W'(1));
  endtask

  task automatic t_unqualified(input logic [W-1:0] keep);
    logic [W-1:0] rd;
    int s;
    a_op(1, 1, 1, 0, 36'hF_0000_0001, rd, s);
    check(a_tx_full_n === 1'b1, "R5 queue write leaves flag", W'(a_tx_full_n), W'(1));
    a_op(1, 1, 0, 1, 36'hF_0000_0002, rd, s);
    check(a_tx_full_n === 1'b1, "R5 disabled write leaves flag", W'(a_tx_full_n), W'(1));
    a_op(0, 1, 1, 1, 36'hF_0000_0003, rd, s);
    check(a_tx_full_n === 1'b1, "R5 deselected write leaves flag", W'(a_tx_full_n), W'(1));
    b_op(1, 1, 1, 0, 36'hF_0000_0004, rd, s);
    check(b_tx_full_n === 1'b1, "R5 port B queue write leaves flag", W'(b_tx_full_n), W'(1));
    b_op(1, 0, 1, 1, '0, rd, s);
    check(rd === keep, "R5 mailbox word unchanged", rd, keep);
    settle();
  endtask

  task automatic t_queue_read_no_release(input logic [W-1:0] d);
    logic [W-1:0] rd;
    int s, n;
    a_op(1, 1, 1, 1, d, rd, s);
    b_op(1, 0, 1, 0, '0, rd, s);
    repeat (10) @(posedge clk_a);
    #1;
    check(a_tx_full_n === 1'b0, "R10 queue read keeps flag low", W'(a_tx_full_n), W'(0));
    b_op(1, 0, 1, 1, '0, rd, s);
    check(rd === d, "R9 b_rdata shows new word", rd, d);
    wait_a_free(s, n);
    check(a_tx_full_n === 1'b1, "R6 release after mailbox read", W'(a_tx_full_n), W'(1));
    settle();
  endtask

  task automatic t_ba_pass(input logic [W-1:0] d1, input logic [W-1:0] d2);
    logic [W-1:0] rd;
    int s, n;
    b_op(1, 1, 1, 1, d1, rd, s);
    check(b_tx_full_n === 1'b0, "R3 b_tx_full_n low after write", W'(b_tx_full_n), W'(0));
    b_op(1, 1, 1, 1, d2, rd, s);
    check(b_tx_full_n === 1'b0, "R4 port B dropped write keeps flag", W'(b_tx_full_n), W'(0));
    a_op(1, 0, 1, 0, '0, rd, s);
    repeat (6) @(posedge clk_b);
    #1;
    check(b_tx_full_n === 1'b0, "R10 port A queue read keeps flag low", W'(b_tx_full_n), W'(0));
    a_op(1, 0, 1, 1, '0, rd, s);
    check(rd === d1, "R4 B-to-A mailbox keeps first word", rd, d1);
    wait_b_free(s, n);
    check(n >= 3 && n <= 4, "R7 clock B edges until release", W'(n), W'(3));
    settle();
  endtask

  initial begin
    rst_n = 1'b0;
    a_sel = 0; a_wr = 0; a_en = 0; a_mb = 0; a_wdata = '0; a_fifo_q = '0;
    b_sel = 0; b_wr = 0; b_en = 0; b_mb = 0; b_wdata = '0; b_fifo_q = '0;
    repeat (4) @(posedge clk_b);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk_b);
    t_reset();
    t_read_mux();
    t_ab_pass(36'h1_2345_6789);
    t_ab_pass(36'hE_DCBA_9876);
    t_blocked_write(36'h3_3333_0001, 36'hC_CCCC_0002);
    t_unqualified(36'h3_3333_0001);
    t_queue_read_no_release(36'h9_F00D_BEEF);
    t_ba_pass(36'h7_0BAD_CAFE, 36'h8_1111_2222);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule